// File: doc/BRIEF.md
# I2C Master SCL Half-Period Timer

This block times the two halves of each SCL period for an I2C master. A one-shot down-counter is loaded from the low bits of a configuration register. On each decrement strobe it counts down toward zero. The strobe fires on two clocks out of every four. When the counter is already at zero, the next strobe ends the half-period. The block then emits a one-clock `tick` and reloads for the following half. The counter never wraps and never runs freely. A full SCL period therefore lasts 4 × (reload + 1) system clocks.

The byte and bit sequencer holds `run` high while a transfer is in progress and drops it when the transfer is complete. The timer drives `scl_release` to tell the sequencer when SCL should be let go. It also samples the wired SCL line on `scl_in`. When the low half ends, the line is released and the timer waits, with its counter loaded and frozen, until SCL is actually seen high. A slave that stretches the clock by holding SCL low therefore shortens no high phase. The high half is always measured from the true rising edge.

The controller has four states:
- `ST_IDLE`: stopped.
- `ST_LOW`: timing the low half.
- `ST_WAIT_HI`: SCL is released and the timer waits for it to read high.
- `ST_HIGH`: timing the high half.

The transitions are:
- start: `ST_IDLE` to `ST_LOW` when `run` is high.
- low_done: `ST_LOW` to `ST_WAIT_HI` on a zero-count strobe.
- line_high: `ST_WAIT_HI` to `ST_HIGH` when `scl_in` is 1.
- high_done: `ST_HIGH` to `ST_LOW` on a zero-count strobe.
- abort: any state to `ST_IDLE` when `run` is low.

The counter is reloaded on start, low_done, line_high and high_done.

Top module: `scl_brg`

## Requirements
- R1: While reset is asserted and after it is released, before `run` is raised, `tick`, `running` and `scl_release` are all 0.
- R2: `running` reads 1 one clock after `run` is first sampled high. The first `tick` follows 2R+2 or 2R+3 clocks after the clock in which `run` was driven high, where R is the reload value. The spread of one clock comes from the free-running strobe phase.
- R3: The counter decrements only on a strobe that occurs in two of every four clocks. With SCL reading high, the tick that ends a low half and the tick that ends the following high half are exactly 2(R+1) clocks apart.
- R4: `tick` is high for exactly one clock at a time.
- R5: `scl_release` is 0 during the low half. It rises in the same clock as the tick that ends the low half.
- R6: While `scl_release` is 1 and `scl_in` is 0, no tick occurs and the count is held. The next tick comes 2R+2 or 2R+3 clocks after the clock in which `scl_in` was driven to 1.
- R7: A reload value of 0 gives a tick on every strobe, that is every 2 clocks, and the timer never locks up.
- R8: Only bits [6:0] of `cfg_reg` form the reload value R. Bit 7 has no effect on any timing.
- R9: When `run` is low, `running` reads 0 one clock later and no further tick appears.
- R10: During the low half `scl_in` is ignored. A high tick followed by a low tick is 2(R+1) clocks apart even when `scl_in` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (oscillator rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reg | input | 8 | Configuration register; low 7 bits are the reload value |
| run | input | 1 | Run request from the transfer sequencer |
| scl_in | input | 1 | Sampled level of the SCL line |
| tick | output | 1 | One-clock pulse at the end of each SCL half-period |
| running | output | 1 | Timer is active |
| scl_release | output | 1 | 1 while SCL should be released (high half or waiting for it) |

## Verification
Each result is due at a known distance from its stimulus.
- `running` changes one clock after `run` changes.
- `scl_release` and the low-half `tick` change in the same clock.
- Ticks separated only by strobes fall exactly 2(R+1) clocks apart.
- A tick that starts from an asynchronous event (`run` raised, or SCL seen high after stretching) lands 2R+2 or 2R+3 clocks later, because the strobe phase is free-running.

The bench drives all inputs just after a falling edge and samples just after the next falling edge. It records the cycle number of every tick and compares the measured gaps with exact values, or with the two-value window, computed from R in bench functions.

// File: rtl/scl_brg_pkg.sv
package scl_brg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_HIGH    = 2'd3
    } brg_state_e;

endpackage

// File: rtl/brg_phase_strobe.sv
module brg_phase_strobe #(
    parameter int PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    localparam int PW = $clog2(PHASES);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    // two strobes per group of four: odd phases
    assign strobe = phase_q[0];

    // R3: strobes never arrive on back-to-back clocks
    assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/brg_down_counter.sv
module brg_down_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);

    // R7: the one-shot never wraps below zero
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/scl_brg.sv
module scl_brg #(
    parameter int CFG_W = 8,
    parameter int RLD_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_reg,
    input  logic             run,
    input  logic             scl_in,
    output logic             tick,
    output logic             running,
    output logic             scl_release
);
    import scl_brg_pkg::*;

    brg_state_e       st_q, st_d;
    logic             strobe;
    logic             load, dec, tick_set;
    logic             zero;
    logic [RLD_W-1:0] count;
    logic [RLD_W-1:0] reload_val;

    assign reload_val = cfg_reg[RLD_W-1:0];

    generate
        if (CFG_W > RLD_W) begin : g_spare_cfg
            logic unused_cfg_hi;
            assign unused_cfg_hi = ^cfg_reg[CFG_W-1:RLD_W];
        end
    endgenerate

    brg_phase_strobe #(.PHASES(4)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    brg_down_counter #(.W(RLD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (reload_val),
        .dec      (dec),
        .count    (count),
        .zero     (zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state and counter control
    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        dec      = 1'b0;
        tick_set = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (run) begin
                    st_d = ST_LOW;
                    load = 1'b1;
                end
            end
            ST_LOW: begin
                if (!run) begin
                    st_d = ST_IDLE;
                end else if (strobe) begin
                    if (zero) begin
                        st_d     = ST_WAIT_HI;
                        load     = 1'b1;
                        tick_set = 1'b1;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            ST_WAIT_HI: begin
                if (!run) begin
                    st_d = ST_IDLE;
                end else if (scl_in) begin
                    st_d = ST_HIGH;
                    load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!run) begin
                    st_d = ST_IDLE;
                end else if (strobe) begin
                    if (zero) begin
                        st_d     = ST_LOW;
                        load     = 1'b1;
                        tick_set = 1'b1;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick        <= 1'b0;
            running     <= 1'b0;
            scl_release <= 1'b0;
        end else begin
            tick        <= tick_set;
            running     <= (st_d != ST_IDLE);
            scl_release <= (st_d == ST_WAIT_HI) || (st_d == ST_HIGH);
        end
    end

    // R4: single-clock tick
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R9: an idle timer is silent
    assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !tick);

    // R5: SCL is released together with the tick that ends the low half
    assert_release_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_release) |-> tick);

    // R6: a stretched line freezes the loaded count
    assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_HI && run && !scl_in) |=> $stable(count));

endmodule

// File: tb/scl_brg_test.sv
module scl_brg_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_reg = 8'h00;
    logic       run = 1'b0;
    logic       scl_in = 1'b1;
    logic       tick, running, scl_release;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    scl_brg uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_reg     (cfg_reg),
        .run         (run),
        .scl_in      (scl_in),
        .tick        (tick),
        .running     (running),
        .scl_release (scl_release)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int half_clocks(input logic [7:0] cfg);
        return 2 * (int'(cfg[6:0]) + 1);
    endfunction

    function automatic int win_lo(input logic [7:0] cfg);
        return 2 * int'(cfg[6:0]) + 2;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int act, input int lo);
        total++;
        if (act < lo || act > lo + 1) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, lo + 1);
        end
    endtask

    task automatic wait_tick(input int limit, output int t);
        t = -1000000;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (tick) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic run_trial(input logic [7:0] cfg, input int stretch);
        int c0, t1, t2, t3, t4, c;
        int hc, lo, lim, seen;
        string tag;
        hc  = half_clocks(cfg);
        lo  = win_lo(cfg);
        lim = 2 * hc + 10;
        tag = (cfg[6:0] == 0) ? "R7" : (cfg[7] ? "R8" : "R3");

        @(negedge clk);
        cfg_reg = cfg;
        scl_in  = 1'b1;
        run     = 1'b1;
        c0      = cyc;
        @(negedge clk);
        chk("R2 running after start", int'(running), 1);
        chk("R5 release low in low half", int'(scl_release), 0);
        wait_tick(lim, t1);
        chk_win({"R2 first tick ", tag}, t1 - c0, lo);
        chk("R5 release with low tick", int'(scl_release), 1);
        @(negedge clk);
        chk("R4 tick one clock", int'(tick), 0);
        wait_tick(lim, t2);
        chk({"R3 low-to-high spacing ", tag}, t2 - t1, hc);
        // low half with SCL held low
        scl_in = 1'b0;
        wait_tick(lim, t3);
        chk("R10 low half ignores scl_in", t3 - t2, hc);
        seen = 0;
        for (int i = 0; i < stretch; i++) begin
            @(negedge clk);
            if (tick || !scl_release) seen++;
        end
        chk("R6 no tick while stretched", seen, 0);
        scl_in = 1'b1;
        c = cyc;
        wait_tick(lim, t4);
        chk_win("R6 high half after release", t4 - c, lo);
        // abort
        run = 1'b0;
        @(negedge clk);
        chk("R9 running drops", int'(running), 0);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        chk("R9 no tick when stopped", seen, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 tick in reset", int'(tick), 0);
        chk("R1 running in reset", int'(running), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 running after reset", int'(running), 0);
        chk("R1 release after reset", int'(scl_release), 0);

        run_trial(8'h00, 3);   // R7
        run_trial(8'h01, 5);
        run_trial(8'h85, 7);   // R8
        run_trial(8'h7F, 2);
        run_trial(8'h80, 4);   // R7 and R8
        for (int k = 0; k < 12; k++) begin
            logic [7:0] rv;
            rv = 8'($urandom_range(0, 255));
            run_trial(rv, int'($urandom_range(1, 40)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        total++;
        bad++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule